// File: doc/BRIEF.md
# Dual Edge Time Capture Unit

This block records the moment at which edges arrive on two timer input pins, using a free-running 16-bit counter that lives outside the block. Each of the two input channels has a pair of 8-bit slots. One slot latches the counter when the pin rises and the other latches it when the pin falls. A firmware-facing read port selects one slot to view, and a write-one-to-clear vector acknowledges the capture flags.

In byte mode the two channels work independently. Channel 0 stores counter bits [7:0] and channel 1 stores bits [15:8]. In joined mode, channel 0's pin alone drives a 16-bit capture. On one edge, the low byte goes to the channel 0 slot and the high byte goes to the channel 1 slot of the same edge type, both taken from the same counter sample. An optional hold mode freezes each slot after its first capture until firmware reads that slot.

Every slot is governed by a two-state machine. In ARMED it accepts edges. The transition CAPTURE_AND_LOCK takes it to LOCKED when an edge arrives while hold is on. In LOCKED, later edges are ignored. The transition RELEASE_ON_READ, triggered by a read of the slot, returns it to ARMED. An edge that arrives while the slot is ARMED and hold is off is captured and leaves the slot in ARMED (transition CAPTURE_STAY).

Top module: `dual_edge_capture`

## Requirements
- R1: After reset all four slot values (`cap_o`), all flags (`flag_o`) and `irq_o` are zero.
- R2: Each pin passes through a two-stage synchronizer and an edge detector. A pin change that is set up before clock edge k is stored with the counter value sampled at edge k+2.
- R3: Slot index = 2*channel + edge type, where edge type 0 means rising and 1 means falling. `cap_o` byte i, at bits [8i+7:8i], is slot i. A rising edge updates only the rising slot of its channel, and a falling edge updates only the falling slot.
- R4: With `cascade_i`=0, channel 0 slots store `cnt_i[7:0]` and channel 1 slots store `cnt_i[15:8]`. Each channel reacts only to its own pin.
- R5: With `cascade_i`=1, an edge on pin 0 loads the channel 0 slot of that edge type with `cnt_i[7:0]` and the channel 1 slot of that type with `cnt_i[15:8]`, both from one sample. Edges on pin 1 have no effect.
- R6: With `hold_i`=0, every detected edge overwrites its slot.
- R7: With `hold_i`=1, a slot that captures becomes locked and ignores further edges. It is released by a read (`rd_i` with `rd_idx_i` equal to its index). In joined mode, both halves of a pair are released by reading the channel 0 slot of that edge type (index 0 or 1).
- R8: Each capture sets the flag of its slot, except the channel 1 slots in joined mode. Writing 1 to `clr_i` bit i clears flag i one edge later. A set in the same cycle takes priority over the clear.
- R9: `irq_o` is high exactly when some flag i is set while `irq_en_i` bit i is 1.
- R10: `rd_data_o` shows, without delay, the value of the slot selected by `rd_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Free-running counter value |
| pin_i | input | 2 | Asynchronous timer input pins, bit = channel |
| cascade_i | input | 1 | Join both channels into one 16-bit capture |
| hold_i | input | 1 | Keep first capture until read |
| irq_en_i | input | 4 | Interrupt enable per slot |
| rd_i | input | 1 | Read strobe, releases a held slot |
| rd_idx_i | input | 2 | Slot selected for reading |
| clr_i | input | 4 | Write-one-to-clear for flags |
| rd_data_o | output | 8 | Value of selected slot |
| cap_o | output | 32 | All slot values, byte i = slot i |
| flag_o | output | 4 | Capture flags per slot |
| irq_o | output | 1 | Combined enabled interrupt |

## Verification
Four properties are checked on every cycle:
- The edge detector never reports two rising edges on consecutive cycles.
- A locked slot keeps its value through the next edge.
- A capture always leaves its flag set.
- A joined capture stores both halves from one counter sample.

The bench's reference model is needed for the rest: the exact two-edge synchronizer latency, the ignoring of pin 1 in joined mode, release on read, set-over-clear priority on the flags, and the masking of the interrupt.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    localparam int NUM_CH   = 2;
    localparam int NUM_SLOT = 2 * NUM_CH;

    typedef enum logic {
        SLOT_ARMED  = 1'b0,
        SLOT_LOCKED = 1'b1
    } slot_state_e;
endpackage

// File: rtl/tcap_edge_det.sv
module tcap_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    assign level = sync_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise_o = level & ~prev_q;
    assign fall_o = ~level & prev_q;

    // R2: a detected rising edge is a single-cycle event
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tcap_slot.sv
module tcap_slot
    import tcap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_i,
    input  logic         hold_i,
    input  logic         rel_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] val_o,
    output logic         cap_o
);
    slot_state_e  st_q, st_d;
    logic [W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_ARMED:  if (ev_i && hold_i) st_d = SLOT_LOCKED; // CAPTURE_AND_LOCK
            SLOT_LOCKED: if (rel_i)          st_d = SLOT_ARMED;  // RELEASE_ON_READ
            default:                         st_d = SLOT_ARMED;
        endcase
    end

    always_comb begin
        cap_o = 1'b0;
        unique case (st_q)
            SLOT_ARMED:  cap_o = ev_i;
            SLOT_LOCKED: cap_o = 1'b0;
            default:     cap_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     val_q <= '0;
        else if (cap_o) val_q <= din_i;
    end

    assign val_o = val_q;

    // R7: a locked slot keeps its value into the next cycle
    assert_locked_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_LOCKED) |=> $stable(val_q));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
    import tcap_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2*BYTE_W-1:0]          cnt_i,
    input  logic [NUM_CH-1:0]            pin_i,
    input  logic                         cascade_i,
    input  logic                         hold_i,
    input  logic [NUM_SLOT-1:0]          irq_en_i,
    input  logic                         rd_i,
    input  logic [1:0]                   rd_idx_i,
    input  logic [NUM_SLOT-1:0]          clr_i,
    output logic [BYTE_W-1:0]            rd_data_o,
    output logic [NUM_SLOT*BYTE_W-1:0]   cap_o,
    output logic [NUM_SLOT-1:0]          flag_o,
    output logic                         irq_o
);
    logic [NUM_CH-1:0]   rise, fall;
    logic [NUM_SLOT-1:0] cap_hit;
    logic [NUM_SLOT-1:0] flag_set;
    logic [NUM_SLOT-1:0] flag_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[c]),
            .rise_o (rise[c]),
            .fall_o (fall[c])
        );
    end

    for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
        localparam int          CH   = i / 2;
        localparam int          FALL = i % 2;
        localparam logic [1:0]  IDX  = 2'(i);
        localparam logic [1:0]  PAIR = 2'(FALL);

        logic              ev_own, ev_joined, ev, rel;
        logic [BYTE_W-1:0] din;

        assign ev_own    = (FALL == 1) ? fall[CH] : rise[CH];
        assign ev_joined = (FALL == 1) ? fall[0]  : rise[0];
        assign ev        = cascade_i ? ev_joined : ev_own;
        assign rel       = rd_i && (rd_idx_i == (cascade_i ? PAIR : IDX));
        assign din       = cnt_i[CH*BYTE_W +: BYTE_W];

        tcap_slot #(.W(BYTE_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev_i   (ev),
            .hold_i (hold_i),
            .rel_i  (rel),
            .din_i  (din),
            .val_o  (cap_o[i*BYTE_W +: BYTE_W]),
            .cap_o  (cap_hit[i])
        );

        if (CH == 0) begin : g_lo
            assign flag_set[i] = cap_hit[i];
        end else begin : g_hi
            assign flag_set[i] = cap_hit[i] && !cascade_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flag_q[i] <= 1'b0;
            else if (flag_set[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i])    flag_q[i] <= 1'b0;
        end

        // R8: a capture that owns a flag leaves it set
        assert_flag_after_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            flag_set[i] |=> flag_o[i]);
    end

    assign flag_o    = flag_q;
    assign irq_o     = |(flag_q & irq_en_i);
    assign rd_data_o = cap_o[rd_idx_i*BYTE_W +: BYTE_W];

    // R5: joined rising capture takes both bytes from one counter sample
    assert_joined_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && cap_hit[0] && cap_hit[2]) |=>
        ({cap_o[2*BYTE_W +: BYTE_W], cap_o[0 +: BYTE_W]} == $past(cnt_i)));
    // R5: same for the falling pair
    assert_joined_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_i && cap_hit[1] && cap_hit[3]) |=>
        ({cap_o[3*BYTE_W +: BYTE_W], cap_o[BYTE_W +: BYTE_W]} == $past(cnt_i)));
endmodule

// File: tb/dual_edge_capture_tb.sv
module dual_edge_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h0000;
    logic [1:0]  pin = 2'b00;
    logic        cascade = 1'b0, hold = 1'b0, rd = 1'b0;
    logic [3:0]  irq_en = 4'h0, clr = 4'h0;
    logic [1:0]  rd_idx = 2'd0;
    logic [7:0]  rd_data;
    logic [31:0] cap;
    logic [3:0]  flag;
    logic        irq;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";

    logic [7:0] m_val [4];
    logic       m_lock [4];
    logic [3:0] m_flag;
    logic [1:0] m1, m2, mp;

    always #2 clk = ~clk;

    dual_edge_capture u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin), .cascade_i(cascade),
        .hold_i(hold), .irq_en_i(irq_en), .rd_i(rd), .rd_idx_i(rd_idx), .clr_i(clr),
        .rd_data_o(rd_data), .cap_o(cap), .flag_o(flag), .irq_o(irq)
    );

    always @(posedge clk) cnt <= cnt + 16'h0103;

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_val[i] = 8'h00; m_lock[i] = 1'b0; end
            m_flag = 4'h0; m1 = 2'b00; m2 = 2'b00; mp = 2'b00;
        end else begin
            logic [1:0] r, f;
            r = m2 & ~mp;
            f = ~m2 & mp;
            for (int i = 0; i < 4; i++) begin
                int src;
                logic ev, rel, set;
                logic [7:0] d;
                src = cascade ? 0 : i / 2;
                ev  = (i % 2 == 1) ? f[src] : r[src];
                d   = (i >= 2) ? cnt[15:8] : cnt[7:0];
                rel = rd && (int'(rd_idx) == (cascade ? i % 2 : i));
                set = 1'b0;
                if (!m_lock[i]) begin
                    if (ev) begin
                        m_val[i] = d; set = 1'b1;
                        if (hold) m_lock[i] = 1'b1;
                    end
                end else if (rel) m_lock[i] = 1'b0;
                if (set && (!cascade || i < 2)) m_flag[i] = 1'b1;
                else if (clr[i])                m_flag[i] = 1'b0;
            end
            mp = m2; m2 = m1; m1 = pin;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks += 4;
            if (cap !== {m_val[3], m_val[2], m_val[1], m_val[0]}) begin
                errors++;
                $display("FAIL %s cap_o actual %h expected %h", cur_req, cap,
                         {m_val[3], m_val[2], m_val[1], m_val[0]});
            end
            if (flag !== m_flag) begin
                errors++;
                $display("FAIL %s flag_o actual %b expected %b", cur_req, flag, m_flag);
            end
            if (irq !== |(m_flag & irq_en)) begin
                errors++;
                $display("FAIL %s irq_o actual %b expected %b", cur_req, irq, |(m_flag & irq_en));
            end
            if (rd_data !== m_val[rd_idx]) begin
                errors++;
                $display("FAIL %s rd_data_o actual %h expected %h", cur_req, rd_data, m_val[rd_idx]);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int ch, input int hi, input int lo);
        pin[ch] = 1'b1; step(hi);
        pin[ch] = 1'b0; step(lo);
    endtask

    task automatic read_slot(input logic [1:0] idx);
        rd_idx = idx; rd = 1'b1; step(1);
        rd = 1'b0;
    endtask

    initial begin
        step(3);
        checks++;
        if (cap !== 32'h0 || flag !== 4'h0 || irq !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state actual %h/%b/%b expected 0/0/0", cap, flag, irq);
        end
        rst_n = 1'b1; step(2);

        cur_req = "R2 R3 R4"; pulse(0, 3, 4); pulse(1, 5, 2); pulse(0, 1, 6);
        cur_req = "R10"; for (int k = 0; k < 4; k++) begin rd_idx = 2'(k); step(1); end
        cur_req = "R6"; repeat (3) pulse(1, 2, 3);
        cur_req = "R8"; clr = 4'hF; step(1); clr = 4'h0; step(3);
        cur_req = "R8 set priority"; pin[0] = 1'b1; step(1); clr = 4'h1; step(3);
        clr = 4'h0; pin[0] = 1'b0; step(4);
        cur_req = "R9"; irq_en = 4'b0100; step(2); irq_en = 4'b0001; clr = 4'h1; step(1);
        clr = 4'h0; irq_en = 4'hF; step(2);
        cur_req = "R7"; hold = 1'b1; clr = 4'hF; step(1); clr = 4'h0;
        pulse(0, 2, 3); pulse(0, 2, 3); pulse(1, 2, 3);
        read_slot(2'd0); step(2); pulse(0, 2, 3);
        read_slot(2'd1); read_slot(2'd2); read_slot(2'd3); step(2);
        pulse(1, 3, 3);
        read_slot(2'd0); read_slot(2'd1); read_slot(2'd2); read_slot(2'd3); step(2);
        cur_req = "R5"; hold = 1'b0; cascade = 1'b1; step(2);
        pulse(0, 4, 4); pulse(1, 3, 3); pulse(0, 1, 5);
        cur_req = "R5 R7 joined hold"; hold = 1'b1; pulse(0, 2, 3); pulse(0, 2, 3);
        read_slot(2'd2); read_slot(2'd3); pulse(0, 2, 3);
        read_slot(2'd0); read_slot(2'd1); pulse(0, 2, 3);
        read_slot(2'd0); read_slot(2'd1); hold = 1'b0;
        cur_req = "R4 back to byte mode"; cascade = 1'b0; step(2);
        pulse(1, 2, 3); pulse(0, 3, 3);
        for (int k = 0; k < 4; k++) begin rd_idx = 2'(k); step(1); end
        step(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule